// File: doc/BRIEF.md
# SONET Transmit Timing Generator

This block runs on the synthesized transmit serial bit clock and derives every slower timing signal the transmit path needs. A word counter, modulo 8 for byte operation or modulo 4 for nibble operation, produces a word-rate clock for upstream multiplexing logic and a one-cycle load strobe for the parallel-to-serial shift register. A second counter divides the bit clock down to the reference frequency and gives the external phase detector its feedback clock and a matching one-cycle pulse.

The feedback modulus depends on both the line rate (155.52 Mbit/s or 622.08 Mbit/s) and the reference select, so that a given reference frequency works at either rate. A sampled copy of the upstream parallel byte clock comes in as well. Each rising edge of that clock re-phases the word counter, so that the serializer load keeps a fixed offset from the upstream data.

The configuration pins are captured once, on the first clock edge after reset is released. Later changes have no effect until the next reset.

Top module: `tx_timing_gen`

## Requirements
- R1: While rst_ni is low, and up to the first rising clock edge after it is released, word_clk_o, load_o, fb_pulse_o and fb_clk_o are all low.
- R2: rate_sel_i, ref_sel_i and nibble_i are captured on the first clock edge after reset release. Changes to them after that alter no output until the next reset.
- R3: The feedback modulus is selected by ref_sel_i = 00, 01, 10, 11. It is 8, 4, 3, 2 when rate_sel_i = 0 (155.52 Mbit/s) and 32, 16, 12, 8 when rate_sel_i = 1 (622.08 Mbit/s).
- R4: fb_pulse_o is high for exactly one cycle per modulus period, odd moduli included. The first pulse comes on the edge numbered equal to the modulus, counting the capture edge as edge 1.
- R5: fb_clk_o is high for floor(modulus/2) cycles, starting in the cycle that follows each fb_pulse_o.
- R6: The word counter has modulus 8 when nibble_i = 0 and 4 when nibble_i = 1. load_o is high for one cycle at its terminal count. Without realignment, the first load comes on edge 8 (or edge 4).
- R7: word_clk_o is high for the first half of each word period: 4 of 8 cycles, or 2 of 4 cycles. It rises in the cycle after load_o.
- R8: A rising edge of pclk_smp_i is a cycle in which it is high after being low in the previous cycle. When it is sampled on an edge, load_o is high exactly ALIGN_LAG+1 edges later (default 3), whatever the counter phase was, and then recurs with the word period.
- R9: pclk_smp_i held high, held low or falling does not change the load cadence. Realignment never changes the timing of fb_pulse_o or fb_clk_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Synthesized serial bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rate_sel_i | input | 1 | 0 = 155.52 Mbit/s line, 1 = 622.08 Mbit/s line |
| ref_sel_i | input | 2 | Reference frequency select (00 19.44, 01 38.88, 10 51.84, 11 77.76 MHz) |
| nibble_i | input | 1 | 1 = 4-bit word, 0 = 8-bit word |
| pclk_smp_i | input | 1 | Sampled upstream parallel byte clock |
| word_clk_o | output | 1 | Word-rate clock for upstream logic |
| load_o | output | 1 | Serializer parallel-load strobe |
| fb_pulse_o | output | 1 | One-cycle feedback pulse per divider period |
| fb_clk_o | output | 1 | Feedback reference clock level |

## Verification
On every cycle the assertions check four things. The outputs stay quiet before the configuration is captured. The captured configuration never changes while running. Each counter stays within its modulus and its terminal strobe never lasts two cycles. After each feedback pulse and each undisturbed load, the matching clock level rises. Only the bench's scenarios can show the rest: the full table of feedback moduli and the first-pulse position, the fixed load offset after a byte-clock edge at every counter phase, that a held or falling byte clock leaves the load cadence alone, and that changed configuration pins stay ignored until a reset.

// File: rtl/tx_timing_pkg.sv
package tx_timing_pkg;

  typedef enum logic {
    RATE_LOW  = 1'b0,  // 155.52 Mbit/s
    RATE_HIGH = 1'b1   // 622.08 Mbit/s
  } rate_e;

  localparam int unsigned FB_W = 5;  // largest modulus 32 -> terminal 31

  typedef struct packed {
    rate_e      rate;
    logic [1:0] ref_sel;
    logic       nibble;
  } tx_cfg_t;

  // Terminal count (modulus - 1) of the feedback divider.
  function automatic logic [FB_W-1:0] fb_last(rate_e rate, logic [1:0] ref_sel);
    logic [5:0] base;
    logic [5:0] modulus;
    case (ref_sel)
      2'd0:    base = 6'd8;
      2'd1:    base = 6'd4;
      2'd2:    base = 6'd3;
      default: base = 6'd2;
    endcase
    modulus = (rate == RATE_HIGH) ? (base << 2) : base;
    return FB_W'(modulus - 6'd1);
  endfunction

endpackage

// File: rtl/tx_cfg_hold.sv
module tx_cfg_hold
  import tx_timing_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  tx_cfg_t cfg_i,
  output tx_cfg_t cfg_o,
  output logic    run_o
);

  tx_cfg_t cfg_q;
  logic    vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      cfg_q <= '0;
    end else if (!vld_q) begin
      vld_q <= 1'b1;
      cfg_q <= cfg_i;
    end
  end

  assign cfg_o = cfg_q;
  assign run_o = vld_q;

  AST_CFG_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(vld_q) |-> $stable(cfg_q)); // R2

endmodule

// File: rtl/tx_mod_counter.sv
module tx_mod_counter #(
  parameter int unsigned W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic [W-1:0] last_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic [W-1:0] cnt_o,
  output logic         tc_o
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    if (!run_i)               cnt_d = '0;
    else if (load_i)          cnt_d = load_val_i;
    else if (cnt_q == last_i) cnt_d = '0;
    else                      cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
  assign tc_o  = run_i && (cnt_q == last_i);

  AST_CNT_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> cnt_q <= last_i); // R3

  AST_TC_ISOLATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tc_o && !load_i && last_i != '0) |=> !tc_o); // R4

endmodule

// File: rtl/tx_edge_det.sv
module tx_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o
);

  logic lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b0;
    else         lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q;

  AST_RISE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o); // R8

endmodule

// File: rtl/tx_timing_gen.sv
module tx_timing_gen
  import tx_timing_pkg::*;
#(
  parameter int unsigned BYTE_W    = 8,
  parameter int unsigned ALIGN_LAG = 2,  // must stay below BYTE_W/2
  parameter bit          NIBBLE_EN = 1'b1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rate_sel_i,
  input  logic [1:0] ref_sel_i,
  input  logic       nibble_i,
  input  logic       pclk_smp_i,
  output logic       word_clk_o,
  output logic       load_o,
  output logic       fb_pulse_o,
  output logic       fb_clk_o
);

  localparam int unsigned WC_W = $clog2(BYTE_W);
  localparam logic [WC_W-1:0] BYTE_LAST = WC_W'(BYTE_W - 1);
  localparam logic [WC_W-1:0] NIB_LAST  = WC_W'(BYTE_W / 2 - 1);
  localparam logic [WC_W-1:0] LAG       = WC_W'(ALIGN_LAG);

  tx_cfg_t cfg_in;
  tx_cfg_t cfg;
  logic    run;

  assign cfg_in = '{rate: rate_e'(rate_sel_i), ref_sel: ref_sel_i, nibble: nibble_i};

  tx_cfg_hold u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cfg_i  (cfg_in),
    .cfg_o  (cfg),
    .run_o  (run)
  );

  // word counter: byte or nibble modulus
  logic [WC_W-1:0] word_last;
  logic [WC_W-1:0] word_preset;
  logic [WC_W-1:0] word_cnt;
  logic            word_tc;
  logic            rise;
  logic            align;

  generate
    if (NIBBLE_EN) begin : g_nib
      assign word_last = cfg.nibble ? NIB_LAST : BYTE_LAST;
    end else begin : g_byte
      assign word_last = BYTE_LAST;
    end
  endgenerate

  // preset places the terminal count ALIGN_LAG edges after the loading edge
  assign word_preset = word_last - LAG;

  tx_edge_det u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (pclk_smp_i),
    .rise_o (rise)
  );

  assign align = rise & run;

  tx_mod_counter #(.W(WC_W)) u_word (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run),
    .last_i     (word_last),
    .load_i     (align),
    .load_val_i (word_preset),
    .cnt_o      (word_cnt),
    .tc_o       (word_tc)
  );

  logic [WC_W:0] word_half;
  assign word_half  = ({1'b0, word_last} + (WC_W+1)'(1)) >> 1;
  assign word_clk_o = run && ({1'b0, word_cnt} < word_half);
  assign load_o     = word_tc;

  // feedback divider: modulus from rate and reference select
  logic [FB_W-1:0] fb_lst;
  logic [FB_W-1:0] fb_cnt;
  logic            fb_tc;
  logic [FB_W:0]   fb_half;

  assign fb_lst = fb_last(cfg.rate, cfg.ref_sel);

  tx_mod_counter #(.W(FB_W)) u_fb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run),
    .last_i     (fb_lst),
    .load_i     (1'b0),
    .load_val_i ('0),
    .cnt_o      (fb_cnt),
    .tc_o       (fb_tc)
  );

  assign fb_half    = ({1'b0, fb_lst} + (FB_W+1)'(1)) >> 1;
  assign fb_clk_o   = run && ({1'b0, fb_cnt} < fb_half);
  assign fb_pulse_o = fb_tc;

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |-> !(word_clk_o || load_o || fb_pulse_o || fb_clk_o)); // R1

  AST_FB_CLK_AFTER_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fb_pulse_o |=> fb_clk_o); // R5

  AST_WORD_CLK_AFTER_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_o && !align) |=> word_clk_o); // R7

  AST_ALIGN_PRESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    align |=> word_cnt == word_preset); // R8

endmodule

// File: tb/tx_timing_gen_bench.sv
module tx_timing_gen_bench;

  localparam int LAG      = 2;
  localparam int WD_LIMIT = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rate = 1'b0;
  logic [1:0] sel = 2'd0;
  logic       nib = 1'b0;
  logic       pclk = 1'b0;
  logic       word_clk, load, fbp, fbc;

  int checks = 0;
  int fails  = 0;
  int wd     = 0;

  // reference state built from the requirements
  bit m_run, m_prev;
  int m_w, m_f, m_wl, m_fl;

  always #4 clk = ~clk;

  tx_timing_gen #(.ALIGN_LAG(LAG)) u_tx_timing_gen (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .rate_sel_i (rate),
    .ref_sel_i  (sel),
    .nibble_i   (nib),
    .pclk_smp_i (pclk),
    .word_clk_o (word_clk),
    .load_o     (load),
    .fb_pulse_o (fbp),
    .fb_clk_o   (fbc)
  );

  function automatic int exp_mod(bit r, logic [1:0] s);
    int b;
    case (s)
      2'd0: b = 8;
      2'd1: b = 4;
      2'd2: b = 3;
      default: b = 2;
    endcase
    return r ? b * 4 : b;
  endfunction

  task automatic chk(bit act, bit exp, string req, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic chk_int(int act, int exp, string req, string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic tick();
    bit rise;
    @(posedge clk);
    if (!rst_n) begin
      m_run = 0; m_prev = 0; m_w = 0; m_f = 0;
    end else begin
      rise   = pclk && !m_prev;
      m_prev = pclk;
      if (!m_run) begin
        m_run = 1; m_w = 0; m_f = 0;
        m_wl = nib ? 3 : 7;
        m_fl = exp_mod(rate, sel) - 1;
      end else begin
        m_w = rise ? m_wl - LAG : ((m_w == m_wl) ? 0 : m_w + 1);
        m_f = (m_f == m_fl) ? 0 : m_f + 1;
      end
    end
    @(negedge clk);
    chk(load,     m_run && m_w == m_wl,            m_run ? "R6" : "R1", "load_o");
    chk(word_clk, m_run && m_w < (m_wl + 1) / 2,   m_run ? "R7" : "R1", "word_clk_o");
    chk(fbp,      m_run && m_f == m_fl,            m_run ? "R4" : "R1", "fb_pulse_o");
    chk(fbc,      m_run && m_f < (m_fl + 1) / 2,   m_run ? "R5" : "R1", "fb_clk_o");
  endtask

  function automatic bit sig(int which);
    return (which == 0) ? load : fbp;
  endfunction

  task automatic first_hit(int which, output int n);
    n = 0;
    do begin
      tick();
      n++;
    end while (!sig(which) && n < 200);
  endtask

  task automatic gap(int which, output int n);
    int d;
    first_hit(which, d);
    first_hit(which, n);
  endtask

  task automatic do_reset(bit r, logic [1:0] s, bit n);
    rst_n = 1'b0; rate = r; sel = s; nib = n; pclk = 1'b0;
    #1;
    chk(load | word_clk | fbp | fbc, 1'b0, "R1", "outputs in reset");
    repeat (3) tick();
    rst_n = 1'b1;
    #1;
    chk(load | word_clk | fbp | fbc, 1'b0, "R1", "outputs after release");
  endtask

  task automatic t_first_strobes();
    int n;
    do_reset(1'b1, 2'd0, 1'b0);
    first_hit(0, n);
    chk_int(n, 8, "R6", "first byte load edge");
    do_reset(1'b1, 2'd0, 1'b1);
    first_hit(0, n);
    chk_int(n, 4, "R6", "first nibble load edge");
    do_reset(1'b1, 2'd2, 1'b0);
    first_hit(1, n);
    chk_int(n, 12, "R4", "first fb pulse edge, modulus 12");
    do_reset(1'b0, 2'd2, 1'b0);
    first_hit(1, n);
    chk_int(n, 3, "R4", "first fb pulse edge, modulus 3");
  endtask

  task automatic t_fb_table();
    int g, hi;
    for (int r = 0; r < 2; r++) begin
      for (int s = 0; s < 4; s++) begin
        do_reset(r[0], s[1:0], 1'b0);
        gap(1, g);
        chk_int(g, exp_mod(r[0], s[1:0]), "R3", "fb pulse spacing");
        hi = 0;
        for (int i = 0; i < g; i++) begin
          tick();
          if (fbc) hi++;
        end
        chk_int(hi, exp_mod(r[0], s[1:0]) / 2, "R5", "fb_clk high cycles");
      end
    end
  endtask

  task automatic t_word();
    int g, hi;
    for (int n = 0; n < 2; n++) begin
      do_reset(1'b0, 2'd1, n[0]);
      gap(0, g);
      chk_int(g, n ? 4 : 8, "R6", "load spacing");
      hi = 0;
      for (int i = 0; i < g; i++) begin
        tick();
        if (word_clk) hi++;
      end
      chk_int(hi, n ? 2 : 4, "R7", "word_clk high cycles");
    end
  endtask

  task automatic t_align();
    int n, g;
    for (int nb = 0; nb < 2; nb++) begin
      do_reset(1'b1, 2'd1, nb[0]);
      for (int ph = 0; ph < 8; ph++) begin
        pclk = 1'b0;
        repeat (ph + 2) tick();
        pclk = 1'b1;
        first_hit(0, n);
        chk_int(n, LAG + 1, "R8", "load offset after byte clock edge");
        gap(0, g);
        chk_int(g, nb ? 4 : 8, "R9", "cadence with byte clock held high");
      end
      pclk = 1'b0;
      gap(0, g);
      chk_int(g, nb ? 4 : 8, "R9", "cadence after byte clock fall");
      gap(1, g);
      chk_int(g, 16, "R9", "fb spacing after realignments");
    end
  endtask

  task automatic t_freeze();
    int g;
    do_reset(1'b1, 2'd0, 1'b0);
    repeat (3) tick();
    rate = 1'b0; sel = 2'd3; nib = 1'b1;
    gap(1, g);
    chk_int(g, 32, "R2", "fb spacing after pin change");
    gap(0, g);
    chk_int(g, 8, "R2", "load spacing after pin change");
    do_reset(1'b0, 2'd3, 1'b1);
    gap(1, g);
    chk_int(g, 2, "R2", "fb spacing after new reset");
    gap(0, g);
    chk_int(g, 4, "R2", "load spacing after new reset");
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > WD_LIMIT) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected<=%0d", wd, WD_LIMIT);
      summary();
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_first_strobes();
    t_fb_table();
    t_word();
    t_align();
    t_freeze();
    summary();
    $finish;
  end

endmodule